// File: doc/BRIEF.md
# Power status and control register target on I2C

This block is a small I2C target that lets a host processor read the power-management status of a board and change one control bit. It answers to the 7-bit device address 0x55. The host writes one byte to select a register index. It then either keeps writing data bytes to that index, or issues a repeated START and reads bytes back from it. The index steps forward after every data byte, so one transaction can move several bytes in a burst.

The readable values come from the power-good vector, the group-enable status, the active-low sequencer fault flag and two revision constants. The only writable bit is the USB power enable, which resets to off. SCL and SDA are synchronised and filtered inside the block. SDA is only ever pulled low, and the block never stretches the clock.

Top module: `pwr_i2c_regs`

## Requirements
- R1: A START followed by address 0x55 is acknowledged. Any other address gets a NACK, and the block does not drive SDA again until the next START or STOP.
- R2: A START (SDA falling while SCL is high) begins a new address phase from any state, and the latched index is kept across it. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R3: In a write transaction the first data byte sets the register index, and each later byte is written to the current index. Every byte is acknowledged.
- R4: Index 0x00 reads the firmware revision (parameter, default 0x03) and index 0x01 reads the board revision (parameter, default 0x02).
- R5: Index 0x06 reads {1'b0, grp_en[6:0]}, which is 0x7F with all seven groups enabled.
- R6: Index 0x08 reads pg_vec[7:0] and index 0x09 reads pg_vec[15:8]. Bit 0 of index 0x08 is pg_vec[0], the module-enable input, and a fully powered board reads 0xFF from both.
- R7: Index 0x0A reads {7'b0, seq_fault_n}.
- R8: Index 0x0E is read-write. Written bit 0 drives usb_pwr_en, the upper bits read as 0, and the bit resets to 0.
- R9: Reads of unmapped indices return 0x00. Writes to read-only or unmapped indices are acknowledged and change nothing.
- R10: The index increments by one, wrapping at 8 bits, after each data byte that is read or written.
- R11: SCL and SDA each pass through two synchroniser flops and a filter that ignores pulses shorter than FILT_LEN clock cycles.
- R12: Read data is sent MSB first, and SDA is only ever driven low. A master ACK fetches the next byte; a master NACK ends the read and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | I2C clock line as seen at the pin |
| sda_in | input | 1 | I2C data line as seen at the pin |
| sda_drive_low | output | 1 | 1 = pull SDA low (open-drain enable) |
| pg_vec | input | PG_W | Power-good vector; bit 0 is the module enable |
| grp_en | input | 7 | Group-enable status, one bit per group |
| seq_fault_n | input | 1 | Sequencer fault status, active low |
| usb_pwr_en | output | 1 | USB power enable from register 0x0E bit 0 |

## Verification
The bench builds the block with its default parameters: address 0x55, revisions 0x03 and 0x02, a 16-bit power-good vector and FILT_LEN of 3. With FILT_LEN at 3, a one-cycle SCL pulse sits inside the filter window. A bus quarter-period of 12 clocks leaves enough margin after the synchroniser and filter delays for the bench to see the effect of the glitch through a register readback. The 8-bit index lets a burst run across the sparse map in one transaction, so a single burst exercises the read-only, unmapped and read-write entries together.

// File: rtl/pwr_i2c_pkg.sv
// Package: state encoding and register indices for the power-status I2C target.
// Assumes nothing beyond an 8-bit index space.
package pwr_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_IDX,
        ST_WR,
        ST_ACK_W,
        ST_RD,
        ST_RD_ACK,
        ST_IGN
    } tgt_state_t;

    localparam logic [7:0] IX_FW_REV   = 8'h00;
    localparam logic [7:0] IX_BRD_REV  = 8'h01;
    localparam logic [7:0] IX_GRP_EN   = 8'h06;
    localparam logic [7:0] IX_PG_LO    = 8'h08;
    localparam logic [7:0] IX_PG_HI    = 8'h09;
    localparam logic [7:0] IX_SEQ_OK   = 8'h0A;
    localparam logic [7:0] IX_USB_CTRL = 8'h0E;

endpackage

// File: rtl/i2c_line_filter.sv
// Synchronises LINES asynchronous bus lines with two flops each, then passes a
// new level on only after it has held for FILT_LEN consecutive clocks.
// Assumes the idle level of every line is 1 (pulled-up bus).
module i2c_line_filter #(
    parameter int LINES    = 2,
    parameter int FILT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [1:0]    sync_q;
        logic          filt_q;
        logic [CW-1:0] cnt_q;

        // Two-stage synchroniser into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= 2'b11;
            else        sync_q <= {sync_q[0], raw[g]};
        end

        // Accept a new level once it has been stable for FILT_LEN cycles.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                filt_q <= 1'b1;
                cnt_q  <= '0;
            end else if (sync_q[1] == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                filt_q <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign clean[g] = filt_q;
    end
endmodule

// File: rtl/i2c_target_fsm.sv
// Bus-level I2C target: START/STOP detection, address match, index latching,
// byte shifting in both directions and ACK generation. Works on filtered
// lines; never stretches SCL. Produces a one-cycle write strobe per data byte.
module i2c_target_fsm
    import pwr_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [7:0] rd_data,
    output logic [7:0] idx,
    output logic       wr_stb,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_drive_low,
    output tgt_state_t st,
    output logic       start_det,
    output logic       stop_det
);
    logic       scl_q, sda_q;
    logic [3:0] bitcnt;
    logic [7:0] sh, tx;
    logic       rw, mack;
    logic       rise, fall;

    assign rise      = scl & ~scl_q;
    assign fall      = ~scl & scl_q;
    assign start_det = scl & scl_q & sda_q & ~sda;
    assign stop_det  = scl & scl_q & ~sda_q & sda;

    // Protocol state machine; all bus actions keyed to filtered SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;  sda_q <= 1'b1;
            st <= ST_IDLE;  sda_drive_low <= 1'b0;
            bitcnt <= '0;   sh <= '0;  tx <= '0;
            idx <= '0;      rw <= 1'b0; mack <= 1'b0;
            wr_stb <= 1'b0; wr_idx <= '0; wr_data <= '0;
        end else begin
            scl_q  <= scl;
            sda_q  <= sda;
            wr_stb <= 1'b0;
            if (start_det) begin
                st <= ST_ADDR; bitcnt <= '0; sda_drive_low <= 1'b0;
            end else if (stop_det) begin
                st <= ST_IDLE; sda_drive_low <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (rise) begin
                            sh <= {sh[6:0], sda}; bitcnt <= bitcnt + 1'b1;
                        end else if (fall && bitcnt == 4'd8) begin
                            if (sh[7:1] == DEV_ADDR) begin
                                sda_drive_low <= 1'b1; rw <= sh[0]; st <= ST_ACK_A;
                            end else begin
                                st <= ST_IGN;
                            end
                        end
                    end
                    ST_ACK_A: if (fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            tx <= rd_data; sda_drive_low <= ~rd_data[7]; st <= ST_RD;
                        end else begin
                            sda_drive_low <= 1'b0; st <= ST_IDX;
                        end
                    end
                    ST_IDX, ST_WR: begin
                        if (rise) begin
                            sh <= {sh[6:0], sda}; bitcnt <= bitcnt + 1'b1;
                        end else if (fall && bitcnt == 4'd8) begin
                            sda_drive_low <= 1'b1; st <= ST_ACK_W;
                            if (st == ST_IDX) begin
                                idx <= sh;
                            end else begin
                                wr_stb <= 1'b1; wr_idx <= idx; wr_data <= sh;
                                idx <= idx + 1'b1;
                            end
                        end
                    end
                    ST_ACK_W: if (fall) begin
                        sda_drive_low <= 1'b0; bitcnt <= '0; st <= ST_WR;
                    end
                    ST_RD: begin
                        if (rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_drive_low <= 1'b0; idx <= idx + 1'b1; st <= ST_RD_ACK;
                            end else begin
                                tx <= {tx[6:0], 1'b0}; sda_drive_low <= ~tx[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (rise) begin
                            mack <= ~sda;
                        end else if (fall) begin
                            if (mack) begin
                                bitcnt <= '0; tx <= rd_data;
                                sda_drive_low <= ~rd_data[7]; st <= ST_RD;
                            end else begin
                                st <= ST_IGN;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pwr_reg_bank.sv
// Sparse register map: read mux over status inputs and revision constants,
// plus the single writable USB power-enable bit. Unmapped reads give 0x00.
module pwr_reg_bank
    import pwr_i2c_pkg::*;
#(
    parameter int         PG_W      = 16,
    parameter logic [7:0] FW_REV    = 8'h03,
    parameter logic [7:0] BOARD_REV = 8'h02
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      rd_idx,
    output logic [7:0]      rd_data,
    input  logic            wr_stb,
    input  logic [7:0]      wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [PG_W-1:0] pg_vec,
    input  logic [6:0]      grp_en,
    input  logic            seq_fault_n,
    output logic            usb_pwr_en
);
    // Holds the USB enable; only index 0x0E accepts writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                               usb_pwr_en <= 1'b0;
        else if (wr_stb && wr_idx == IX_USB_CTRL) usb_pwr_en <= wr_data[0];
    end

    // Read decode for the current index.
    always_comb begin
        case (rd_idx)
            IX_FW_REV:   rd_data = FW_REV;
            IX_BRD_REV:  rd_data = BOARD_REV;
            IX_GRP_EN:   rd_data = {1'b0, grp_en};
            IX_PG_LO:    rd_data = pg_vec[7:0];
            IX_PG_HI:    rd_data = pg_vec[15:8];
            IX_SEQ_OK:   rd_data = {7'b0, seq_fault_n};
            IX_USB_CTRL: rd_data = {7'b0, usb_pwr_en};
            default:     rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/pwr_i2c_regs.sv
// Top: filtered I2C target at a fixed address serving the power status map.
// Assumes an external pull-up on SDA; sda_drive_low enables the low driver.
module pwr_i2c_regs
    import pwr_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h55,
    parameter logic [7:0] FW_REV    = 8'h03,
    parameter logic [7:0] BOARD_REV = 8'h02,
    parameter int         PG_W      = 16,
    parameter int         FILT_LEN  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            sda_drive_low,
    input  logic [PG_W-1:0] pg_vec,
    input  logic [6:0]      grp_en,
    input  logic            seq_fault_n,
    output logic            usb_pwr_en
);
    logic [1:0] clean;
    logic [7:0] idx, rd_data, wr_idx, wr_data;
    logic       wr_stb, start_det, stop_det;
    tgt_state_t fsm_st;

    i2c_line_filter #(.LINES(2), .FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .clean(clean)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl(clean[1]), .sda(clean[0]),
        .rd_data(rd_data), .idx(idx), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .wr_data(wr_data), .sda_drive_low(sda_drive_low), .st(fsm_st),
        .start_det(start_det), .stop_det(stop_det)
    );

    pwr_reg_bank #(.PG_W(PG_W), .FW_REV(FW_REV), .BOARD_REV(BOARD_REV)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
        .pg_vec(pg_vec), .grp_en(grp_en), .seq_fault_n(seq_fault_n),
        .usb_pwr_en(usb_pwr_en)
    );
endmodule

// File: rtl/pwr_i2c_regs_chk.sv
// Checker for pwr_i2c_regs: protocol-state and register-write properties.
module pwr_i2c_regs_chk
    import pwr_i2c_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input tgt_state_t st,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_drive_low,
    input logic       usb_pwr_en,
    input logic       wr_stb,
    input logic [7:0] wr_idx
);
    AST_NO_DRIVE_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_ADDR || st == ST_IGN) |-> !sda_drive_low); // R1
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR)); // R2
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_drive_low)); // R2
    AST_USB_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_pwr_en != $past(usb_pwr_en)) |-> $past(wr_stb && wr_idx == IX_USB_CTRL)); // R8
    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R3
endmodule

bind pwr_i2c_regs pwr_i2c_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(fsm_st), .start_det(start_det),
    .stop_det(stop_det), .sda_drive_low(sda_drive_low),
    .usb_pwr_en(usb_pwr_en), .wr_stb(wr_stb), .wr_idx(wr_idx)
);

// File: tb/sim_pwr_i2c_regs.sv
module sim_pwr_i2c_regs;
    localparam int CLK_NS = 10;
    localparam int Q      = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_drive_low, usb_pwr_en;
    logic [15:0] pg_vec = 16'hC3A5;
    logic [6:0]  grp_en = 7'h5B;
    logic        seq_fault_n = 1'b1;
    logic        sda_bus;
    int checks = 0, errors = 0;
    logic glitch_en = 1'b0;
    logic mon_en = 1'b0, drv_seen = 1'b0;

    assign sda_bus = sda_m & ~sda_drive_low;
    always #(CLK_NS/2) clk = ~clk;

    pwr_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_drive_low(sda_drive_low), .pg_vec(pg_vec), .grp_en(grp_en),
        .seq_fault_n(seq_fault_n), .usb_pwr_en(usb_pwr_en)
    );

    always @(posedge clk) if (mon_en && sda_drive_low) drv_seen <= 1'b1;

    // idx, expected read value, with pg=C3A5 grp=5B fault_n=1 usb=0
    localparam logic [15:0] VEC [9] = '{
        16'h0003, 16'h0102, 16'h065B, 16'h08A5, 16'h09C3,
        16'h0A01, 16'h0E00, 16'h0500, 16'h0F00
    };

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b, output logic s);
        sda_m = b;
        if (glitch_en) begin
            wq(Q/2); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q/2 - 1);
        end else wq(Q);
        scl_m = 1'b1; wq(Q);
        s = sda_bus;
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i], s);
        put_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, s); d[i] = s;
        end
        put_bit(~mack, s);
    endtask

    task automatic reg_write(input logic [7:0] ix, input logic [7:0] v, input string req);
        logic a;
        i2c_start;
        wr_byte({7'h55, 1'b0}, a); chk({7'b0, a}, 8'h01, req);
        wr_byte(ix, a);
        wr_byte(v, a); chk({7'b0, a}, 8'h01, req);
        i2c_stop;
    endtask

    task automatic reg_read(input logic [7:0] ix, output logic [7:0] d);
        logic a;
        i2c_start;
        wr_byte({7'h55, 1'b0}, a);
        wr_byte(ix, a);
        i2c_start;
        wr_byte({7'h55, 1'b1}, a);
        rd_byte(1'b0, d);
        i2c_stop;
    endtask

    initial begin : main
        logic [7:0] d;
        logic a;
        wq(5);
        // reset state: R8 usb off, R12 SDA released
        chk({7'b0, usb_pwr_en}, 8'h00, "R8 reset");
        chk({7'b0, sda_drive_low}, 8'h00, "R12 reset");
        rst_n = 1'b1; wq(10);

        // table walk: R4 R5 R6 R7 R8 R9 via write-index + repeated START (R2) read
        foreach (VEC[k]) begin
            reg_read(VEC[k][15:8], d);
            chk(d, VEC[k][7:0], $sformatf("R4-map idx %h", VEC[k][15:8]));
        end

        // R8 R3: write 0x0E sets USB enable, readback shows only bit 0
        reg_write(8'h0E, 8'hFF, "R3 ack");
        chk({7'b0, usb_pwr_en}, 8'h01, "R8 usb on");
        reg_read(8'h0E, d); chk(d, 8'h01, "R8 readback");

        // R9: write to read-only index acknowledged and ignored
        reg_write(8'h00, 8'h77, "R9 ack");
        reg_read(8'h00, d); chk(d, 8'h03, "R9 ro ignored");
        reg_write(8'h20, 8'h01, "R9 unmapped ack");
        reg_read(8'h20, d); chk(d, 8'h00, "R9 unmapped read");

        // R1: foreign address NACKed, bytes after it ignored, SDA never driven
        drv_seen = 1'b0; mon_en = 1'b1;
        i2c_start;
        wr_byte({7'h22, 1'b0}, a); chk({7'b0, a}, 8'h00, "R1 nack");
        wr_byte(8'h0E, a); wr_byte(8'h00, a);
        i2c_stop; mon_en = 1'b0;
        chk({7'b0, drv_seen}, 8'h00, "R1 no drive");
        chk({7'b0, usb_pwr_en}, 8'h01, "R1 ignored");

        // R10 R12: burst read 0x08..0x0A with master ACKs, final NACK
        i2c_start;
        wr_byte({7'h55, 1'b0}, a); wr_byte(8'h08, a);
        i2c_start;
        wr_byte({7'h55, 1'b1}, a); chk({7'b0, a}, 8'h01, "R1 ack read");
        rd_byte(1'b1, d); chk(d, 8'hA5, "R10 burst 0");
        rd_byte(1'b1, d); chk(d, 8'hC3, "R10 burst 1");
        rd_byte(1'b0, d); chk(d, 8'h01, "R10 burst 2");
        wq(2);
        chk({7'b0, sda_drive_low}, 8'h00, "R12 released after nack");
        i2c_stop;
        chk({7'b0, sda_drive_low}, 8'h00, "R2 idle after stop");

        // R10 R3: burst write from 0x0D, second byte lands in 0x0E
        i2c_start;
        wr_byte({7'h55, 1'b0}, a); wr_byte(8'h0D, a);
        wr_byte(8'h55, a); wr_byte(8'h00, a);
        i2c_stop;
        chk({7'b0, usb_pwr_en}, 8'h00, "R10 write increment");

        // R10: index wraps 0xFF -> 0x00
        i2c_start;
        wr_byte({7'h55, 1'b0}, a); wr_byte(8'hFF, a);
        i2c_start;
        wr_byte({7'h55, 1'b1}, a);
        rd_byte(1'b1, d); chk(d, 8'h00, "R10 wrap ff");
        rd_byte(1'b0, d); chk(d, 8'h03, "R10 wrap 00");
        i2c_stop;

        // R11: one-cycle SCL glitches during index byte are filtered
        i2c_start;
        wr_byte({7'h55, 1'b0}, a);
        glitch_en = 1'b1; wr_byte(8'h06, a); glitch_en = 1'b0;
        i2c_start;
        wr_byte({7'h55, 1'b1}, a);
        rd_byte(1'b0, d); chk(d, 8'h5B, "R11 glitch");
        i2c_stop;

        // R5 R6 R7: fully powered values and a fault
        pg_vec = 16'hFFFF; grp_en = 7'h7F; seq_fault_n = 1'b0; wq(4);
        reg_read(8'h08, d); chk(d, 8'hFF, "R6 full lo");
        reg_read(8'h09, d); chk(d, 8'hFF, "R6 full hi");
        reg_read(8'h06, d); chk(d, 8'h7F, "R5 full");
        reg_read(8'h0A, d); chk(d, 8'h00, "R7 fault");
        pg_vec = 16'hFFFE; wq(4);
        reg_read(8'h08, d); chk(d, 8'hFE, "R6 module enable bit0");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule